// File: doc/BRIEF.md
# Flash Write Controller with Nested Suspend

This block is the embedded write controller of a parallel flash. Writes arrive on a single bus strobe that carries an address and a data word. The low byte of the data word is read as a command, except on the second cycle of a two-cycle sequence. The block runs word program, block erase, whole-array erase and OTP word program. Down-counters take the place of the array timing. A status byte reports whether the engine is ready, which operations are suspended, and any errors. A flat register array stands in for the main memory, and a small register file stands in for the OTP words.

An erase in progress may be suspended, and a word program may then run inside that suspension. The nested program may itself be suspended, so one program and one erase can be suspended at the same time. In that case a resume always continues the program first. Whole-array erase and OTP program cannot be interrupted. Block protection comes from outside the block as a single input, sampled with the second cycle of a sequence.

Top module: `flash_wsm`

## Requirements
- R1: After rst_ni is released, status_o reads 0x80 and reads return the main array. Asserting rst_ni during a running program abandons it and leaves the target word unchanged.
- R2: The command 0x40 followed by an address and data word starts a program. status_o[7] stays 0 for PROG_CYC cycles after the data cycle. The word then holds its old value ANDed with the data, so bits only go from 1 to 0.
- R3: The command 0x20 followed by 0xD0 at any address of a block erases that block. status_o[7] stays 0 for ERASE_CYC cycles. Afterwards every word of that block reads all ones and other blocks keep their contents. Any other value on the second cycle cancels the sequence.
- R4: The command 0x30 followed by 0xD0 erases the whole array in CHIP_CYC cycles.
- R5: If blk_prot_i is 1 on the second cycle of a program or block erase, nothing is written and status_o[7] stays 1. Status bit 1 is set, together with bit 4 for a program or bit 5 for an erase.
- R6: The status byte is laid out as {ready, erase suspended, erase error, program error, 0, program suspended, protect hit, 0}. The error and protect bits persist until the command 0x50.
- R7: The command 0xB0 during a program or block erase keeps status_o[7] at 0 for SUSP_LAT-1 cycles. status_o[7] rises SUSP_LAT cycles after the command, together with the matching suspend bit, and the array is not yet altered.
- R8: While an erase is suspended, a program may start. While a program is suspended, any program, erase or whole-array erase command is ignored.
- R9: The command 0xD0 outside a sequence resumes the suspended program if there is one, and otherwise the suspended erase. Each operation then finishes with its intended result.
- R10: A suspend command during a whole-array erase or an OTP program is ignored. The operation ends at its normal time and no suspend bit is set.
- R11: The command 0xC0 followed by an address and data programs an OTP word. Only addresses 0x80 to 0x88 are accepted; any other address sets bit 4. The word at 0x80 holds two lock bits: bit 0 at 0 locks 0x81 to 0x84, and bit 1 at 0 locks 0x85 to 0x88. A write to a locked word sets bit 4 and leaves the word unchanged. The command 0x90 makes reads show OTP words at 0x80 to 0x88 and all ones elsewhere, and 0xFF returns reads to the main array.
- R12: An OTP program command given while an erase is suspended is ignored. Status and OTP contents are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; aborts any operation |
| wr_i | input | 1 | Bus write strobe, one cycle per write |
| addr_i | input | AW | Word address for writes and reads |
| data_i | input | DW | Command in the low byte, or program data |
| blk_prot_i | input | 1 | Protection state of the addressed block |
| rdata_o | output | DW | Read data at addr_i from the main array or the OTP words |
| status_o | output | 8 | Status byte |

## Verification
The hardest state to reach from the ports is one where a program and an erase are suspended at the same time. The bench gets there by starting a block erase and suspending it after a few cycles. It then starts a program inside that suspension and suspends the program as well. In that state it sends erase and program commands that must be ignored. It then resumes twice, checking the status and array contents after each resume, to show that the program finishes first and the erase second. It also tries an OTP program while only the erase is suspended and checks that the attempt is ignored.

// File: rtl/fwsm_pkg.sv
package fwsm_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_PROG  = 3'd1,
    OP_ERASE = 3'd2,
    OP_CHIP  = 3'd3,
    OP_OTP   = 3'd4
  } op_e;

  localparam logic [7:0] CMD_PROG     = 8'h40;
  localparam logic [7:0] CMD_ERASE    = 8'h20;
  localparam logic [7:0] CMD_CHIP     = 8'h30;
  localparam logic [7:0] CMD_OTP      = 8'hC0;
  localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND  = 8'hB0;
  localparam logic [7:0] CMD_CLEAR    = 8'h50;
  localparam logic [7:0] CMD_RD_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_RD_OTP   = 8'h90;

  localparam int OTP_BASE      = 128;
  localparam int OTP_WORDS     = 9;
  localparam int OTP_FAC_FIRST = OTP_BASE + 1;
  localparam int OTP_FAC_LAST  = OTP_BASE + 4;
  localparam int OTP_CUS_FIRST = OTP_BASE + 5;
  localparam int OTP_CUS_LAST  = OTP_BASE + 8;
endpackage

// File: rtl/fwsm_cmd_dec.sv
module fwsm_cmd_dec
  import fwsm_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          busy_i,
  output op_e           op_o,
  output logic [AW-1:0] op_addr_o,
  output logic [DW-1:0] op_data_o,
  output logic          susp_o,
  output logic          resume_o,
  output logic          clr_o,
  output logic          rd_otp_o
);
  op_e  armed_q, armed_d;
  logic rd_otp_q, rd_otp_d;
  logic [7:0] cmd;

  assign cmd = data_i[7:0];

  always_comb begin
    armed_d  = armed_q;
    rd_otp_d = rd_otp_q;
    op_o     = OP_NONE;
    susp_o   = 1'b0;
    resume_o = 1'b0;
    clr_o    = 1'b0;
    if (wr_i) begin
      if (armed_q != OP_NONE) begin
        armed_d = OP_NONE;
        unique case (armed_q)
          OP_PROG, OP_OTP:  op_o = armed_q;
          OP_ERASE, OP_CHIP: if (cmd == CMD_CONFIRM) op_o = armed_q;
          default: ;
        endcase
      end else begin
        unique case (cmd)
          CMD_PROG:     if (!busy_i) armed_d = OP_PROG;
          CMD_ERASE:    if (!busy_i) armed_d = OP_ERASE;
          CMD_CHIP:     if (!busy_i) armed_d = OP_CHIP;
          CMD_OTP:      if (!busy_i) armed_d = OP_OTP;
          CMD_SUSPEND:  susp_o   = 1'b1;
          CMD_CONFIRM:  resume_o = 1'b1;
          CMD_CLEAR:    clr_o    = 1'b1;
          CMD_RD_ARRAY: rd_otp_d = 1'b0;
          CMD_RD_OTP:   rd_otp_d = 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign op_addr_o = addr_i;
  assign op_data_o = data_i;
  assign rd_otp_o  = rd_otp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= OP_NONE;
      rd_otp_q <= 1'b0;
    end else begin
      armed_q  <= armed_d;
      rd_otp_q <= rd_otp_d;
    end
  end

  // a second cycle always ends the sequence, confirmed or not
  assert_seq_ends_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && armed_q != OP_NONE) |=> (armed_q == OP_NONE));

  assert_one_request_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({op_o != OP_NONE, susp_o, resume_o, clr_o}));
endmodule

// File: rtl/fwsm_seq.sv
module fwsm_seq
  import fwsm_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 16,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 24,
  parameter int CHIP_CYC  = 40,
  parameter int SUSP_LAT  = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  op_e           op_i,
  input  logic [AW-1:0] op_addr_i,
  input  logic [DW-1:0] op_data_i,
  input  logic          susp_i,
  input  logic          resume_i,
  input  logic          clr_i,
  input  logic          prot_i,
  input  logic [1:0]    otp_lock_i,
  output logic [7:0]    status_o,
  output logic          busy_o,
  output op_e           commit_o,
  output logic [AW-1:0] commit_addr_o,
  output logic [DW-1:0] commit_data_o
);
  localparam int MAX_PE = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int MAXC   = (MAX_PE > CHIP_CYC) ? MAX_PE : CHIP_CYC;
  localparam int CW     = $clog2(MAXC + 1);
  localparam int SW     = $clog2(SUSP_LAT + 1);

  localparam logic [CW-1:0] PROG_LD  = CW'(PROG_CYC - 1);
  localparam logic [CW-1:0] ERASE_LD = CW'(ERASE_CYC - 1);
  localparam logic [CW-1:0] CHIP_LD  = CW'(CHIP_CYC - 1);
  localparam logic [SW-1:0] SUSP_LD  = SW'(SUSP_LAT - 1);

  op_e           run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d, p_cnt_q, p_cnt_d, e_cnt_q, e_cnt_d;
  logic [SW-1:0] scnt_q, scnt_d;
  logic          pend_q, pend_d;
  logic          p_susp_q, p_susp_d, e_susp_q, e_susp_d;
  logic [AW-1:0] p_addr_q, p_addr_d, e_addr_q, e_addr_d;
  logic [DW-1:0] p_data_q, p_data_d;
  logic          perr_q, perr_d, eerr_q, eerr_d, prot_q, prot_d;
  logic          ready, otp_in_rng, otp_locked;

  assign ready = (run_q == OP_NONE) && !pend_q;

  assign otp_in_rng = (op_addr_i >= AW'(OTP_BASE)) &&
                      (op_addr_i <= AW'(OTP_BASE + OTP_WORDS - 1));
  assign otp_locked = (otp_lock_i[0] && op_addr_i >= AW'(OTP_FAC_FIRST) &&
                       op_addr_i <= AW'(OTP_FAC_LAST)) ||
                      (otp_lock_i[1] && op_addr_i >= AW'(OTP_CUS_FIRST) &&
                       op_addr_i <= AW'(OTP_CUS_LAST));

  always_comb begin
    run_d    = run_q;    cnt_d    = cnt_q;
    p_cnt_d  = p_cnt_q;  e_cnt_d  = e_cnt_q;
    scnt_d   = scnt_q;   pend_d   = pend_q;
    p_susp_d = p_susp_q; e_susp_d = e_susp_q;
    p_addr_d = p_addr_q; e_addr_d = e_addr_q;
    p_data_d = p_data_q;
    perr_d   = perr_q;   eerr_d   = eerr_q;   prot_d = prot_q;
    commit_o = OP_NONE;

    if (run_q != OP_NONE) begin
      if (cnt_q == '0) begin
        // completion wins over a pending suspend
        commit_o = run_q;
        run_d    = OP_NONE;
        pend_d   = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
        if (pend_q) begin
          if (scnt_q == '0) begin
            pend_d = 1'b0;
            run_d  = OP_NONE;
            if (run_q == OP_PROG) begin
              p_susp_d = 1'b1;
              p_cnt_d  = cnt_q - 1'b1;
            end else begin
              e_susp_d = 1'b1;
              e_cnt_d  = cnt_q - 1'b1;
            end
          end else begin
            scnt_d = scnt_q - 1'b1;
          end
        end else if (susp_i && (run_q == OP_PROG || run_q == OP_ERASE)) begin
          pend_d = 1'b1;
          scnt_d = SUSP_LD;
        end
      end
    end else begin
      unique case (op_i)
        OP_PROG: if (!p_susp_q) begin
          if (prot_i) begin
            perr_d = 1'b1;
            prot_d = 1'b1;
          end else begin
            run_d    = OP_PROG;
            cnt_d    = PROG_LD;
            p_addr_d = op_addr_i;
            p_data_d = op_data_i;
          end
        end
        OP_ERASE: if (!p_susp_q && !e_susp_q) begin
          if (prot_i) begin
            eerr_d = 1'b1;
            prot_d = 1'b1;
          end else begin
            run_d    = OP_ERASE;
            cnt_d    = ERASE_LD;
            e_addr_d = op_addr_i;
          end
        end
        OP_CHIP: if (!p_susp_q && !e_susp_q) begin
          run_d = OP_CHIP;
          cnt_d = CHIP_LD;
        end
        OP_OTP: if (!p_susp_q && !e_susp_q) begin
          if (!otp_in_rng || otp_locked) begin
            perr_d = 1'b1;
          end else begin
            run_d    = OP_OTP;
            cnt_d    = PROG_LD;
            p_addr_d = op_addr_i;
            p_data_d = op_data_i;
          end
        end
        default: ;
      endcase
      if (resume_i) begin
        if (p_susp_q) begin
          run_d    = OP_PROG;
          cnt_d    = p_cnt_q;
          p_susp_d = 1'b0;
        end else if (e_susp_q) begin
          run_d    = OP_ERASE;
          cnt_d    = e_cnt_q;
          e_susp_d = 1'b0;
        end
      end
    end

    if (clr_i) begin
      perr_d = 1'b0;
      eerr_d = 1'b0;
      prot_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= OP_NONE;
      cnt_q    <= '0;
      p_cnt_q  <= '0;
      e_cnt_q  <= '0;
      scnt_q   <= '0;
      pend_q   <= 1'b0;
      p_susp_q <= 1'b0;
      e_susp_q <= 1'b0;
      p_addr_q <= '0;
      e_addr_q <= '0;
      p_data_q <= '0;
      perr_q   <= 1'b0;
      eerr_q   <= 1'b0;
      prot_q   <= 1'b0;
    end else begin
      run_q    <= run_d;
      cnt_q    <= cnt_d;
      p_cnt_q  <= p_cnt_d;
      e_cnt_q  <= e_cnt_d;
      scnt_q   <= scnt_d;
      pend_q   <= pend_d;
      p_susp_q <= p_susp_d;
      e_susp_q <= e_susp_d;
      p_addr_q <= p_addr_d;
      e_addr_q <= e_addr_d;
      p_data_q <= p_data_d;
      perr_q   <= perr_d;
      eerr_q   <= eerr_d;
      prot_q   <= prot_d;
    end
  end

  assign status_o      = {ready, e_susp_q, eerr_q, perr_q, 1'b0, p_susp_q, prot_q, 1'b0};
  assign busy_o        = !ready;
  assign commit_addr_o = (run_q == OP_ERASE) ? e_addr_q : p_addr_q;
  assign commit_data_o = p_data_q;

  assert_psusp_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_susp_q |-> (run_q != OP_ERASE && run_q != OP_CHIP && run_q != OP_OTP));

  assert_prog_first_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resume_i && ready && p_susp_q && e_susp_q) |=> (run_q == OP_PROG && e_susp_q));

  assert_no_susp_chip_otp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q == OP_CHIP || run_q == OP_OTP) |=> !pend_q);

  assert_susp_after_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[6]) |-> $past(pend_q));

  assert_err_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (perr_q && !clr_i) |=> perr_q);
endmodule

// File: rtl/fwsm_store.sv
module fwsm_store
  import fwsm_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DW     = 16,
  parameter int BLK_AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  op_e           commit_i,
  input  logic [AW-1:0] commit_addr_i,
  input  logic [DW-1:0] commit_data_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic          rd_otp_i,
  output logic [DW-1:0] rdata_o,
  output logic [1:0]    otp_lock_o
);
  localparam int WORDS = 2 ** AW;

  logic [DW-1:0] mem_q [WORDS];
  logic [DW-1:0] otp_w [OTP_WORDS];
  logic [DW-1:0] otp_rd;

  // array keeps contents across reset, as a nonvolatile store would
  always_ff @(posedge clk_i) begin
    for (int i = 0; i < WORDS; i++) begin
      if (commit_i == OP_CHIP ||
          (commit_i == OP_ERASE && (AW'(i) >> BLK_AW) == (commit_addr_i >> BLK_AW)))
        mem_q[i] <= '1;
      else if (commit_i == OP_PROG && AW'(i) == commit_addr_i)
        mem_q[i] <= mem_q[i] & commit_data_i;
    end
  end

  for (genvar k = 0; k < OTP_WORDS; k++) begin : g_otp
    logic [DW-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        word_q <= '1;
      else if (commit_i == OP_OTP && commit_addr_i == AW'(OTP_BASE + k))
        word_q <= word_q & commit_data_i;
    end
    assign otp_w[k] = word_q;
  end

  always_comb begin
    otp_rd = '1;
    for (int k = 0; k < OTP_WORDS; k++)
      if (rd_addr_i == AW'(OTP_BASE + k)) otp_rd = otp_w[k];
  end

  assign rdata_o    = rd_otp_i ? otp_rd : mem_q[rd_addr_i];
  assign otp_lock_o = ~otp_w[0][1:0];

  assert_prog_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i == OP_PROG) |=> ((mem_q[$past(commit_addr_i)] & ~$past(commit_data_i)) == '0));

  assert_erase_fills_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i == OP_ERASE) |=> (mem_q[$past(commit_addr_i)] == '1));
endmodule

// File: rtl/flash_wsm.sv
module flash_wsm
  import fwsm_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 16,
  parameter int BLK_AW    = 4,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 24,
  parameter int CHIP_CYC  = 40,
  parameter int SUSP_LAT  = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          blk_prot_i,
  output logic [DW-1:0] rdata_o,
  output logic [7:0]    status_o
);
  op_e           op, commit;
  logic [AW-1:0] op_addr, commit_addr;
  logic [DW-1:0] op_data, commit_data;
  logic          susp, resume, clr, rd_otp, busy;
  logic [1:0]    otp_lock;

  fwsm_cmd_dec #(.AW(AW), .DW(DW)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .data_i    (data_i),
    .busy_i    (busy),
    .op_o      (op),
    .op_addr_o (op_addr),
    .op_data_o (op_data),
    .susp_o    (susp),
    .resume_o  (resume),
    .clr_o     (clr),
    .rd_otp_o  (rd_otp)
  );

  fwsm_seq #(
    .AW(AW), .DW(DW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
    .CHIP_CYC(CHIP_CYC), .SUSP_LAT(SUSP_LAT)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .op_i          (op),
    .op_addr_i     (op_addr),
    .op_data_i     (op_data),
    .susp_i        (susp),
    .resume_i      (resume),
    .clr_i         (clr),
    .prot_i        (blk_prot_i),
    .otp_lock_i    (otp_lock),
    .status_o      (status_o),
    .busy_o        (busy),
    .commit_o      (commit),
    .commit_addr_o (commit_addr),
    .commit_data_o (commit_data)
  );

  fwsm_store #(.AW(AW), .DW(DW), .BLK_AW(BLK_AW)) u_store (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .commit_i      (commit),
    .commit_addr_i (commit_addr),
    .commit_data_i (commit_data),
    .rd_addr_i     (addr_i),
    .rd_otp_i      (rd_otp),
    .rdata_o       (rdata_o),
    .otp_lock_o    (otp_lock)
  );
endmodule

// File: tb/flash_wsm_tb.sv
`timescale 1ns/1ps
module flash_wsm_tb;
  localparam int AW = 8, DW = 16, BLK_AW = 4;
  localparam int PROG_CYC = 8, ERASE_CYC = 24, CHIP_CYC = 40, SUSP_LAT = 3;
  localparam int NVEC = 6;
  // {addr, data, expected word}
  localparam logic [39:0] VEC [NVEC] = '{
    {8'h10, 16'h1234, 16'h1234},
    {8'h11, 16'hABCD, 16'hABCD},
    {8'h10, 16'hFF0F, 16'h1204},
    {8'h1F, 16'h0000, 16'h0000},
    {8'h11, 16'h5555, 16'h0145},
    {8'h12, 16'hFFFF, 16'hFFFF}
  };

  logic clk = 1'b0, rst_ni = 1'b0, wr_i = 1'b0, blk_prot_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic [DW-1:0] rdata_o;
  logic [7:0]    status_o;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  flash_wsm #(
    .AW(AW), .DW(DW), .BLK_AW(BLK_AW), .PROG_CYC(PROG_CYC),
    .ERASE_CYC(ERASE_CYC), .CHIP_CYC(CHIP_CYC), .SUSP_LAT(SUSP_LAT)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i), .data_i(data_i),
    .blk_prot_i(blk_prot_i), .rdata_o(rdata_o), .status_o(status_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    wr_i = 1'b1; addr_i = a; data_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic wait_rdy();
    for (int i = 0; i < 500 && !status_o[7]; i++) @(negedge clk);
  endtask

  task automatic chk_word(input string req, input logic [7:0] a, input logic [15:0] exp);
    addr_i = a;
    #1;
    chk(req, rdata_o, exp);
  endtask

  task automatic prog(input logic [7:0] a, input logic [15:0] d);
    wr(a, 16'h0040); wr(a, d); wait_rdy();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1 act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 reset status", status_o, 8'h80);

    // whole-array erase, suspend attempt ignored
    wr(8'h00, 16'h0030); wr(8'h00, 16'h00D0);
    chk("R4 busy at start", status_o[7], 1'b0);
    wr(8'h00, 16'h00B0);
    repeat (CHIP_CYC - 2) @(negedge clk);
    chk("R10 chip erase not suspended", status_o, 8'h00);
    @(negedge clk);
    chk("R4 chip erase done", status_o, 8'h80);
    chk_word("R4 word 00", 8'h00, 16'hFFFF);
    chk_word("R4 word FF", 8'hFF, 16'hFFFF);

    // program timing
    wr(8'h25, 16'h0040); wr(8'h25, 16'h0000);
    repeat (PROG_CYC - 1) @(negedge clk);
    chk("R2 busy window", status_o[7], 1'b0);
    @(negedge clk);
    chk("R2 ready after program", status_o, 8'h80);
    chk_word("R2 word 25", 8'h25, 16'h0000);

    // program vector table
    for (int i = 0; i < NVEC; i++) begin
      prog(VEC[i][39:32], VEC[i][31:16]);
      chk_word("R2 table", VEC[i][39:32], VEC[i][15:0]);
    end

    // erase cancel, then real erase of block 1
    wr(8'h10, 16'h0020); wr(8'h10, 16'h00FF);
    chk("R3 cancel status", status_o, 8'h80);
    chk_word("R3 cancel keeps data", 8'h10, 16'h1204);
    wr(8'h13, 16'h0020); wr(8'h13, 16'h00D0);
    repeat (ERASE_CYC - 1) @(negedge clk);
    chk("R3 busy window", status_o[7], 1'b0);
    @(negedge clk);
    chk("R3 erase done", status_o, 8'h80);
    chk_word("R3 first word", 8'h10, 16'hFFFF);
    chk_word("R3 last word", 8'h1F, 16'hFFFF);
    chk_word("R3 other block", 8'h25, 16'h0000);

    // protection and sticky errors
    blk_prot_i = 1'b1;
    wr(8'h30, 16'h0040); wr(8'h30, 16'h0000);
    chk("R5 protected program", status_o, 8'h92);
    chk_word("R5 word kept", 8'h30, 16'hFFFF);
    wr(8'h30, 16'h0020); wr(8'h30, 16'h00D0);
    chk("R5 protected erase", status_o, 8'hB2);
    blk_prot_i = 1'b0;
    prog(8'h31, 16'h7777);
    chk("R6 errors sticky", status_o, 8'hB2);
    chk_word("R6 program ok", 8'h31, 16'h7777);
    wr(8'h00, 16'h0050);
    chk("R6 clear", status_o, 8'h80);

    // OTP
    wr(8'h81, 16'h00C0); wr(8'h81, 16'h1111); wait_rdy();
    chk("R11 otp program status", status_o, 8'h80);
    wr(8'h00, 16'h0090);
    chk_word("R11 otp word 81", 8'h81, 16'h1111);
    chk_word("R11 otp outside", 8'h25, 16'hFFFF);
    wr(8'h89, 16'h00C0); wr(8'h89, 16'h0000);
    chk("R11 out of range", status_o, 8'h90);
    wr(8'h00, 16'h0050);
    wr(8'h80, 16'h00C0); wr(8'h80, 16'hFFFE); wait_rdy();
    wr(8'h82, 16'h00C0); wr(8'h82, 16'h0000);
    chk("R11 factory locked", status_o, 8'h90);
    chk_word("R11 locked word kept", 8'h82, 16'hFFFF);
    wr(8'h00, 16'h0050);
    wr(8'h85, 16'h00C0); wr(8'h85, 16'h00AA); wait_rdy();
    chk("R11 customer open", status_o, 8'h80);
    chk_word("R11 customer word", 8'h85, 16'h00AA);
    wr(8'h00, 16'h00FF);
    chk_word("R11 back to array", 8'h25, 16'h0000);

    // nested suspend
    wr(8'h20, 16'h0020); wr(8'h20, 16'h00D0);
    repeat (4) @(negedge clk);
    wr(8'h20, 16'h00B0);
    repeat (SUSP_LAT - 1) @(negedge clk);
    chk("R7 not ready inside latency", status_o[7], 1'b0);
    @(negedge clk);
    chk("R7 erase suspended", status_o, 8'hC0);
    chk_word("R7 block not erased", 8'h25, 16'h0000);
    wr(8'h30, 16'h0040); wr(8'h30, 16'h00F0);
    repeat (2) @(negedge clk);
    wr(8'h00, 16'h00B0);
    wait_rdy();
    chk("R8 both suspended", status_o, 8'hC4);
    wr(8'h35, 16'h0020); wr(8'h35, 16'h00D0);
    chk("R8 erase ignored", status_o, 8'hC4);
    wr(8'h36, 16'h0040); wr(8'h36, 16'h0000);
    chk("R8 program ignored", status_o, 8'hC4);
    chk_word("R8 word 36 kept", 8'h36, 16'hFFFF);
    chk_word("R8 program not committed", 8'h30, 16'hFFFF);
    wr(8'h00, 16'h00D0);
    chk("R9 resume busy", status_o[7], 1'b0);
    wait_rdy();
    chk("R9 program resumed first", status_o, 8'hC0);
    chk_word("R9 program result", 8'h30, 16'h00F0);
    chk_word("R9 erase still pending", 8'h25, 16'h0000);
    wr(8'h86, 16'h00C0); wr(8'h86, 16'h0000);
    chk("R12 otp rejected", status_o, 8'hC0);
    wr(8'h00, 16'h00D0);
    wait_rdy();
    chk("R9 erase resumed", status_o, 8'h80);
    chk_word("R9 erase result", 8'h25, 16'hFFFF);
    chk_word("R9 erase last word", 8'h2F, 16'hFFFF);
    wr(8'h00, 16'h0090);
    chk_word("R12 otp word kept", 8'h86, 16'hFFFF);
    wr(8'h00, 16'h00FF);

    // OTP program cannot be suspended
    wr(8'h87, 16'h00C0); wr(8'h87, 16'hFF00);
    wr(8'h00, 16'h00B0);
    repeat (PROG_CYC - 2) @(negedge clk);
    chk("R10 otp not suspended", status_o, 8'h00);
    @(negedge clk);
    chk("R10 otp done", status_o, 8'h80);

    // reset aborts a running program
    wr(8'h40, 16'h0040); wr(8'h40, 16'h1234);
    repeat (3) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    chk("R1 status after abort", status_o, 8'h80);
    chk_word("R1 word untouched", 8'h40, 16'hFFFF);
    @(negedge clk);
    prog(8'h40, 16'h1234);
    chk_word("R1 usable after reset", 8'h40, 16'h1234);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule